// File: doc/BRIEF.md
# Multichannel Bank Reader and Serializer

This block empties one read bank of a ping-pong buffer and turns its contents into 32 parallel serial bit streams, one for each channel. The bank holds 32 partitions of 32 words each. Partition p holds the data of channel p. After a start pulse the block issues one read per clock. It visits every partition at one in-partition offset before it moves to the next offset. Each returned word goes into a per-channel staging register. When a video bit period ends, all 32 staging words move together into 16-bit shift registers. The shift registers then move one bit out on every video-clock falling edge.

The falling edges of the video clock arrive as a one-cycle enable, `vid_tick`, in the system clock domain. A free-running 4-bit tick counter marks every sixteenth tick as a word boundary, and new words are loaded only there. The memory returns data one clock after a read. When the final word has been captured, the block pulses `bank_drained` so that the writer can swap banks. It then waits for the next start.

Top module: `bank_serializer`

## Requirements
- R1: While reset is asserted, and after it until a start, `rd_en`, `bank_drained` and every bit of `sdout` are 0.
- R2: `rd_addr` carries the partition index in bits [9:5] and the in-partition offset in bits [4:0]. Within one offset, successive reads step the partition by one, from 0 to 31.
- R3: After partition 31 the next read is partition 0 at the offset plus one. A bank is read as exactly 1024 reads, starting at address 0, with each address read once.
- R4: Channel c (`sdout[c]`) outputs the words of partition c in ascending offset order. Each word goes out MSB first, and the output changes at the clock edge that samples `vid_tick` high.
- R5: All channels change together. When ticks are at least 3 clocks apart, the word at offset k+1 follows offset k on the outputs with no gap.
- R6: Tick indices count from 0 after reset. Words are loaded only at tick indices 16n+15, so the first bit of a word appears after such a tick, and the outputs stay 0 before the first load.
- R7: `bank_drained` is high for exactly one clock, two clocks after the read of address 1023 is issued. No read is issued after it until the next start.
- R8: A start pulse while a bank is being read has no effect: the reads, the data and the drained pulse are the same as without it.
- R9: Once the last word of a bank has been shifted out, every `sdout` bit is 0.
- R10: `rd_data` is taken as the word for the address issued with `rd_en` in the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to drain the current read bank |
| vid_tick | input | 1 | One-cycle enable marking a video-clock falling edge |
| rd_data | input | 16 | Read data, valid one clock after `rd_en` |
| rd_en | output | 1 | Read strobe for `rd_addr` |
| rd_addr | output | 10 | Read address: partition [9:5], offset [4:0] |
| sdout | output | 32 | Serial output bit for each channel |
| bank_drained | output | 1 | One-cycle pulse after the last word is captured |

## Verification
The hardest case to reach is a word boundary where the staging bank is only just full. The last capture of a round competes with the boundary tick, and only a short tick period makes that happen on every round. The bench drains one bank with ticks every 16 clocks, one with ticks every 3 clocks, and one with extra start pulses during the run. In each case it checks that all 32 words per channel come out back to back, starting at the first boundary tick that follows the fill.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_TAIL = 2'd2
    } seq_state_e;

endpackage

// File: rtl/bsr_seq.sv
module bsr_seq
    import bsr_pkg::*;
#(
    parameter int PART_BITS = 5,
    parameter int OFF_BITS  = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          stage_full,
    output logic                          rd_en,
    output logic [PART_BITS+OFF_BITS-1:0] rd_addr,
    output logic [PART_BITS-1:0]          rd_part,
    output logic                          round_end,
    output logic                          drained
);

    localparam int CNT_W = PART_BITS + OFF_BITS;

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             drained;
    } seq_s;

    seq_s seq_d, seq_q;

    always_comb begin
        seq_d         = seq_q;
        seq_d.drained = 1'b0;
        rd_en         = 1'b0;
        case (seq_q.st)
            SEQ_IDLE: begin
                if (start) begin
                    seq_d.st  = SEQ_RUN;
                    seq_d.cnt = '0;
                end
            end
            SEQ_RUN: begin
                if (!stage_full) begin
                    rd_en     = 1'b1;
                    seq_d.cnt = seq_q.cnt + 1'b1;
                    if (seq_q.cnt == {CNT_W{1'b1}}) begin
                        seq_d.st = SEQ_TAIL;
                    end
                end
            end
            SEQ_TAIL: begin
                seq_d.drained = 1'b1;
                seq_d.st      = SEQ_IDLE;
            end
            default: seq_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.st      <= SEQ_IDLE;
            seq_q.cnt     <= '0;
            seq_q.drained <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    // The fast-counting low half of the counter becomes the partition field.
    assign rd_addr   = {seq_q.cnt[PART_BITS-1:0], seq_q.cnt[CNT_W-1:PART_BITS]};
    assign rd_part   = seq_q.cnt[PART_BITS-1:0];
    assign round_end = rd_en && (rd_part == {PART_BITS{1'b1}});
    assign drained   = seq_q.drained;

    // Tracker of the previously issued address, used only by the checks below.
    logic [CNT_W-1:0] prev_addr_q;
    logic             prev_vld_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_addr_q <= '0;
            prev_vld_q  <= 1'b0;
        end else if (rd_en) begin
            prev_addr_q <= rd_addr;
            prev_vld_q  <= 1'b1;
        end else if (seq_q.st == SEQ_IDLE) begin
            prev_vld_q  <= 1'b0;
        end
    end

    a_r2_partition_step: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && prev_vld_q && (prev_addr_q[CNT_W-1:OFF_BITS] != {PART_BITS{1'b1}})
        |-> (rd_addr[CNT_W-1:OFF_BITS] == prev_addr_q[CNT_W-1:OFF_BITS] + 1'b1)
            && (rd_addr[OFF_BITS-1:0] == prev_addr_q[OFF_BITS-1:0]));

    a_r3_offset_carry: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && prev_vld_q && (prev_addr_q[CNT_W-1:OFF_BITS] == {PART_BITS{1'b1}})
        |-> (rd_addr[CNT_W-1:OFF_BITS] == '0)
            && (rd_addr[OFF_BITS-1:0] == prev_addr_q[OFF_BITS-1:0] + 1'b1));

    a_r7_drain_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        drained |-> $past(rd_en, 2) && ($past(rd_addr, 2) == {CNT_W{1'b1}}));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        drained |=> !drained);

endmodule

// File: rtl/bsr_stage.sv
module bsr_stage #(
    parameter int PART_BITS = 5,
    parameter int WORD_W    = 16
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   rd_en,
    input  logic [PART_BITS-1:0]                   rd_part,
    input  logic                                   round_end,
    input  logic [WORD_W-1:0]                      rd_data,
    input  logic                                   load,
    output logic                                   full,
    output logic                                   ready,
    output logic [(1<<PART_BITS)-1:0][WORD_W-1:0]  words
);

    localparam int NCH = 1 << PART_BITS;

    typedef struct packed {
        logic                          pend;
        logic [PART_BITS-1:0]          part;
        logic                          full;
        logic [NCH-1:0][WORD_W-1:0]    words;
    } stage_s;

    stage_s stg_d, stg_q;

    always_comb begin
        stg_d      = stg_q;
        stg_d.pend = rd_en;
        stg_d.part = rd_part;
        if (stg_q.pend) begin
            stg_d.words[stg_q.part] = rd_data;
        end
        if (round_end) begin
            stg_d.full = 1'b1;
        end else if (load) begin
            stg_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign full  = stg_q.full;
    assign ready = stg_q.full && !stg_q.pend;
    assign words = stg_q.words;

    a_r5_full_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stg_q.full) |-> stg_q.pend && (stg_q.part == {PART_BITS{1'b1}}));

endmodule

// File: rtl/bsr_shift.sv
module bsr_shift #(
    parameter int NCH      = 32,
    parameter int WORD_W   = 16,
    parameter int BITCNT_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick,
    input  logic                          ready,
    input  logic [NCH-1:0][WORD_W-1:0]    words,
    output logic                          load,
    output logic [NCH-1:0]                sdout
);

    typedef struct packed {
        logic [BITCNT_W-1:0]          bcnt;
        logic [NCH-1:0][WORD_W-1:0]   sr;
    } shift_s;

    shift_s sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        load = tick && (sh_q.bcnt == {BITCNT_W{1'b1}}) && ready;
        if (tick) begin
            sh_d.bcnt = sh_q.bcnt + 1'b1;
            if (load) begin
                sh_d.sr = words;
            end else begin
                for (int c = 0; c < NCH; c++) begin
                    sh_d.sr[c] = {sh_q.sr[c][WORD_W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_lane
        assign sdout[g] = sh_q.sr[g][WORD_W-1];
    end

endmodule

// File: rtl/bank_serializer.sv
module bank_serializer #(
    parameter int PART_BITS = 5,
    parameter int OFF_BITS  = 5,
    parameter int WORD_W    = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          vid_tick,
    input  logic [WORD_W-1:0]             rd_data,
    output logic                          rd_en,
    output logic [PART_BITS+OFF_BITS-1:0] rd_addr,
    output logic [(1<<PART_BITS)-1:0]     sdout,
    output logic                          bank_drained
);

    localparam int NCH      = 1 << PART_BITS;
    localparam int BITCNT_W = $clog2(WORD_W);

    logic                          stage_full;
    logic                          stage_ready;
    logic                          load;
    logic                          round_end;
    logic [PART_BITS-1:0]          rd_part;
    logic [NCH-1:0][WORD_W-1:0]    words;

    bsr_seq #(
        .PART_BITS (PART_BITS),
        .OFF_BITS  (OFF_BITS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .stage_full (stage_full),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .rd_part    (rd_part),
        .round_end  (round_end),
        .drained    (bank_drained)
    );

    bsr_stage #(
        .PART_BITS (PART_BITS),
        .WORD_W    (WORD_W)
    ) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .rd_part   (rd_part),
        .round_end (round_end),
        .rd_data   (rd_data),
        .load      (load),
        .full      (stage_full),
        .ready     (stage_ready),
        .words     (words)
    );

    bsr_shift #(
        .NCH      (NCH),
        .WORD_W   (WORD_W),
        .BITCNT_W (BITCNT_W)
    ) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (vid_tick),
        .ready (stage_ready),
        .words (words),
        .load  (load),
        .sdout (sdout)
    );

endmodule

// File: tb/bank_serializer_tb.sv
`timescale 1ns/1ps
module bank_serializer_tb;

    localparam int NS_MAX = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        vid_tick = 1'b0;
    logic [15:0] rd_data = '0;
    logic        rd_en;
    logic [9:0]  rd_addr;
    logic [31:0] sdout;
    logic        bank_drained;

    int checks = 0;
    int errors = 0;
    int period = 16;
    int div = 0;
    int tick_no = 0;
    int ns = 0;
    logic [31:0] samples [NS_MAX];
    int          stick   [NS_MAX];
    int cyc = 0;
    int nreads = 0, ndrain = 0, addr_err = 0, late_reads = 0, drain_err = 0;
    int last_rd_cyc = 0;
    logic [31:0] seed = 32'h1234;
    logic        done = 1'b0;

    bank_serializer u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .vid_tick     (vid_tick),
        .rd_data      (rd_data),
        .rd_en        (rd_en),
        .rd_addr      (rd_addr),
        .sdout        (sdout),
        .bank_drained (bank_drained)
    );

    always #2.5 clk = ~clk;

    function automatic logic [15:0] word_of(input logic [31:0] s, input logic [9:0] a);
        logic [31:0] h;
        h = 32'(a) * 32'd40503 + s;
        return (h[15:0] ^ h[18:3]) | 16'h8000;
    endfunction

    // Memory model: one clock read latency (R10)
    always_ff @(posedge clk) begin
        if (rd_en) rd_data <= word_of(seed, rd_addr);
    end

    // Tick generation, output sampling and read monitoring, all at the falling edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (vid_tick) begin
            if (ns < NS_MAX) begin
                samples[ns] = sdout;
                stick[ns]   = tick_no;
                ns = ns + 1;
            end
            tick_no = tick_no + 1;
        end
        if (rd_en) begin
            if (rd_addr != {nreads[4:0], nreads[9:5]}) addr_err = addr_err + 1;
            if (ndrain != 0) late_reads = late_reads + 1;
            nreads = nreads + 1;
            last_rd_cyc = cyc;
        end
        if (bank_drained) begin
            if (cyc - last_rd_cyc != 2) drain_err = drain_err + 1;
            ndrain = ndrain + 1;
        end
        if (!rst_n) begin
            vid_tick = 1'b0;
            div = 0;
        end else if (div >= period - 1) begin
            vid_tick = 1'b1;
            div = 0;
        end else begin
            vid_tick = 1'b0;
            div = div + 1;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic test_reset();
        check(sdout == 0 && !rd_en && !bank_drained, "R1 outputs during reset",
              {sdout, 6'b0, rd_en, bank_drained}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        check(sdout == 0 && !rd_en && !bank_drained && nreads == 0, "R1 idle after reset",
              {sdout, 6'b0, rd_en, bank_drained}, 0);
    endtask

    task automatic run_bank(input logic [31:0] s, input int per, input bit noise, input string tag);
        int guard;
        int j;
        int bad;
        int first_bad;
        logic [31:0] exp_v;
        logic [31:0] act_bad, exp_bad;
        period = per;
        seed = s;
        repeat (2 * per + 2) @(negedge clk);
        ns = 0; nreads = 0; ndrain = 0; addr_err = 0; late_reads = 0; drain_err = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (noise) begin
            repeat (100) @(negedge clk);
            start = 1'b1; @(negedge clk); start = 1'b0;
            repeat (3000) @(negedge clk);
            start = 1'b1; @(negedge clk); start = 1'b0;
        end
        guard = 0;
        while (ndrain == 0 && guard < 40000) begin
            @(negedge clk);
            guard = guard + 1;
        end
        repeat (16 * per * 4) @(negedge clk);

        check(addr_err == 0, {"R2 partition-major address order ", tag}, addr_err, 0);
        check(nreads == 1024, {"R3 read count ", tag}, nreads, 1024);
        check(ndrain == 1 && drain_err == 0, {"R7 single drained pulse two clocks after last read ", tag},
              ndrain * 16 + drain_err, 16);
        check(late_reads == 0, {"R7 no reads after drained ", tag}, late_reads, 0);
        if (noise) check(nreads == 1024 && ndrain == 1, "R8 start while busy ignored", nreads, 1024);

        // First load: first boundary tick whose following output is nonzero
        j = -1;
        for (int k = 0; k < ns; k++) begin
            if (j < 0 && samples[k] != 0) j = k;
        end
        check(j >= 0 && (stick[j] % 16) == 15, {"R6 first word follows a boundary tick ", tag},
              (j >= 0) ? stick[j] % 16 : -1, 15);
        if (j < 0 || j + 528 > ns) begin
            check(1'b0, {"R4 stream capture length ", tag}, ns, j + 528);
            return;
        end
        bad = 0; first_bad = -1; act_bad = '0; exp_bad = '0;
        for (int b = 0; b < 512; b++) begin
            for (int c = 0; c < 32; c++) begin
                logic [15:0] w;
                w = word_of(s, {c[4:0], 5'(b / 16)});
                exp_v[c] = w[15 - (b % 16)];
            end
            if (samples[j + b] != exp_v) begin
                bad = bad + 1;
                if (first_bad < 0) begin
                    first_bad = b; act_bad = samples[j + b]; exp_bad = exp_v;
                end
            end
        end
        // R4/R5/R10: per-channel data, MSB first, lockstep, gap-free across offsets
        check(bad == 0, {"R4 R5 R10 serial streams ", tag}, act_bad, exp_bad);
        bad = 0;
        for (int b = 512; b < 528; b++) if (samples[j + b] != 0) bad = bad + 1;
        check(bad == 0, {"R9 outputs zero after last word ", tag}, bad, 0);
    endtask

    initial begin
        test_reset();
        run_bank(32'h0000_1234, 16, 1'b0, "slow ticks");
        run_bank(32'h00A5_0F0F, 3, 1'b0, "fast ticks");
        run_bank(32'h0777_3C21, 8, 1'b1, "start noise");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule